// File: doc/BRIEF.md
# Indexed Display Control Register File

This block holds the control state of a simple linear-framebuffer display. Software reaches it over a small memory-mapped bus with two windows. The control window is a bank of 16-bit registers placed every two bytes, so the register index is the byte address shifted right by one. Two slots in that bank are answered by the block itself and cannot be stored to. Slot 0 returns a fixed version word. Slot 10 returns the configured video memory size counted in 64 KiB units. Any read beyond slot 10 returns all ones. The extension window holds two 32-bit registers: a read-only window-size word and a byte-order control that keeps a big-endian framebuffer flag.

The stored values are driven straight onto output ports for a downstream mode calculator: enable, bits per pixel, horizontal and vertical resolution, virtual width, x and y panning offsets, and the byte-order flag. A read is answered one cycle after the request, through a registered data bus with a valid strobe. Writes take effect at the clock edge that accepts them.

Access sizes are encoded as 0 = one byte, 1 = two bytes, 2 = four bytes, and 3 = reserved. The reserved size is ignored and reads back zero.

Top module: `dispctl_regs`

## Requirements
- R1: A two-byte write to the control window (win=0) at byte address A stores all 16 bits of wdata[15:0] into register A>>1, and address bit 0 is ignored. The stored value appears on the matching output port and reads back as {16'h0, value}. Slot map: 1 horizontal resolution, 2 vertical resolution, 3 bits per pixel, 4 enable, 5 bank, 6 virtual width, 7 virtual height, 8 x offset, 9 y offset.
- R2: Reads of slot 0 always return the version constant 16'hB0C5, whatever was written there.
- R3: Reads of slot 10 return VMEM_BYTES/65536, which is 16'h0100 with the default 16 MiB.
- R4: A read of any slot above 10 returns 16'hFFFF for that halfword. A write to slot 10 or above changes no register.
- R5: A one-byte access uses the upper byte of the register when address bit 0 is 1 and the lower byte when it is 0. A write replaces only that byte, taking its value from wdata[7:0]. A read returns the byte zero-extended.
- R6: A four-byte access to the control window covers slots A>>1 and (A>>1)+1. The lower slot maps to bits 15:0 and the higher slot to bits 31:16.
- R7: A four-byte read at extension offset 0 returns the window size EXT_SIZE, which is 8 by default.
- R8: Extension offset 4 reads 32'hBEBEBEBE while the big-endian flag is set and 32'h1E1E1E1E while it is clear. A four-byte write of 32'hBEBEBEBE sets the flag, a write of 32'h1E1E1E1E clears it, and any other value leaves it unchanged.
- R9: An extension access that is not four bytes wide, or that targets an offset other than 0 or 4, reads zero and changes nothing.
- R10: After reset, all stored registers, every output port and the byte-order flag are zero, and rvalid is low.
- R11: rvalid is high in exactly the cycle after a read request and low otherwise. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| win | input | 1 | 0 = control bank, 1 = extension window |
| addr | input | ADDR_W | Byte address within the selected window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response strobe |
| out_enable | output | 16 | Raw enable register |
| out_bpp | output | 16 | Raw bits-per-pixel register |
| out_xres | output | 16 | Raw horizontal resolution |
| out_yres | output | 16 | Raw vertical resolution |
| out_vwidth | output | 16 | Raw virtual width |
| out_xoff | output | 16 | Raw x panning offset |
| out_yoff | output | 16 | Raw y panning offset |
| out_big_endian | output | 1 | Big-endian framebuffer flag |

## Verification
Several properties are checked on every cycle:
- the response strobe timing;
- the version constant returned for slot-0 halfword reads;
- the bank staying unchanged when a write lands only on out-of-range slots;
- the byte-order flag moving only on a full-width write of a magic value.

The bench scenarios cover the rest:
- byte-lane merging;
- word accesses that straddle two slots, including one that crosses into the synthesized and out-of-range region;
- the memory-size slot;
- rejection of narrow and misplaced extension accesses, checked through readback and the output ports.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  // Slot indices decoded by the downstream mode calculator
  localparam int SLOT_ID      = 0;
  localparam int SLOT_XRES    = 1;
  localparam int SLOT_YRES    = 2;
  localparam int SLOT_BPP     = 3;
  localparam int SLOT_ENABLE  = 4;
  localparam int SLOT_BANK    = 5;
  localparam int SLOT_VWIDTH  = 6;
  localparam int SLOT_VHEIGHT = 7;
  localparam int SLOT_XOFF    = 8;
  localparam int SLOT_YOFF    = 9;
  localparam int SLOT_VMEM    = 10;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Memory size in 64 KiB units
  function automatic logic [15:0] vmem_units(input logic [31:0] bytes);
    return bytes[31:16];
  endfunction

  // Byte enables of the first lane for a given size and address parity
  function automatic logic [1:0] first_lane_be(input acc_size_e sz, input logic odd);
    case (sz)
      SZ_BYTE: return odd ? 2'b10 : 2'b01;
      SZ_HALF, SZ_WORD: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // Assemble the read word from the two halfword lanes
  function automatic logic [31:0] pack_read(input acc_size_e sz, input logic odd,
                                            input logic [15:0] lo, input logic [15:0] hi);
    case (sz)
      SZ_BYTE: return {24'h0, (odd ? lo[15:8] : lo[7:0])};
      SZ_HALF: return {16'h0, lo};
      SZ_WORD: return {hi, lo};
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/dcr_lane_map.sv
module dcr_lane_map
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic [31:0]           wdata,
  output logic [1:0][IDX_W-1:0] lane_idx,
  output logic [1:0]            lane_on,
  output logic [1:0][1:0]       lane_be,
  output logic [1:0][15:0]      lane_dat
);

  acc_size_e sz;
  logic [IDX_W-1:0] base_idx;

  assign sz       = acc_size_e'(size);
  assign base_idx = {1'b0, addr[ADDR_W-1:1]};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_idx[l] = base_idx + IDX_W'(l);
    if (l == 0) begin : g_first
      assign lane_on[l]  = (sz != SZ_RSVD);
      assign lane_be[l]  = first_lane_be(sz, addr[0]);
      assign lane_dat[l] = (sz == SZ_BYTE) ? {2{wdata[7:0]}} : wdata[15:0];
    end else begin : g_second
      assign lane_on[l]  = (sz == SZ_WORD);
      assign lane_be[l]  = 2'b11;
      assign lane_dat[l] = wdata[31:16];
    end
  end

endmodule

// File: rtl/dcr_bank.sv
module dcr_bank #(
  parameter int NREG  = 10,
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0][IDX_W-1:0] lane_idx,
  input  logic [1:0]            lane_on,
  input  logic [1:0][1:0]       lane_be,
  input  logic [1:0][15:0]      lane_dat,
  output logic [NREG-1:0][15:0] regs
);

  // Named event: some lane of this write lands on a stored slot
  logic any_in_range;
  always_comb begin
    any_in_range = 1'b0;
    for (int l = 0; l < 2; l++)
      if (lane_on[l] && (lane_idx[l] < IDX_W'(NREG))) any_in_range = 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [15:0] q;
    logic [1:0]  hit0, hit1;
    assign hit0 = (wr_en && lane_on[0] && lane_idx[0] == IDX_W'(i)) ? lane_be[0] : 2'b00;
    assign hit1 = (wr_en && lane_on[1] && lane_idx[1] == IDX_W'(i)) ? lane_be[1] : 2'b00;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= 16'h0;
      end else begin
        for (int b = 0; b < 2; b++) begin
          if (hit0[b])      q[8*b +: 8] <= lane_dat[0][8*b +: 8];
          else if (hit1[b]) q[8*b +: 8] <= lane_dat[1][8*b +: 8];
        end
      end
    end
    assign regs[i] = q;
  end

  p_oor_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_in_range) |=> $stable(regs));

endmodule

// File: rtl/dcr_ext.sv
module dcr_ext
  import dcr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] EXT_SIZE  = 32'h8,
  parameter logic [31:0] MAGIC_BE  = 32'hBEBE_BEBE,
  parameter logic [31:0] MAGIC_LE  = 32'h1E1E_1E1E,
  parameter int          OFF_SIZE  = 0,
  parameter int          OFF_ORDER = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic              big_endian,
  output logic [31:0]       rd_val
);

  logic full_width;
  logic order_wr;
  logic set_be, set_le;

  assign full_width = (acc_size_e'(size) == SZ_WORD);
  assign order_wr   = acc && wr && full_width && (addr == ADDR_W'(OFF_ORDER));
  assign set_be     = order_wr && (wdata == MAGIC_BE);
  assign set_le     = order_wr && (wdata == MAGIC_LE);

  always_ff @(posedge clk) begin
    if (!rst_n)      big_endian <= 1'b0;
    else if (set_be) big_endian <= 1'b1;
    else if (set_le) big_endian <= 1'b0;
  end

  always_comb begin
    rd_val = 32'h0;
    if (full_width) begin
      if (addr == ADDR_W'(OFF_SIZE))       rd_val = EXT_SIZE;
      else if (addr == ADDR_W'(OFF_ORDER)) rd_val = big_endian ? MAGIC_BE : MAGIC_LE;
    end
  end

  p_flag_magic_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && wdata != MAGIC_BE && wdata != MAGIC_LE) |=> $stable(big_endian));
  p_narrow_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && !full_width) |=> $stable(big_endian));
  p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_be |=> big_endian);

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
  import dcr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          NREG       = 10,
  parameter logic [15:0] VERSION_ID = 16'hB0C5,
  parameter logic [31:0] VMEM_BYTES = 32'h0100_0000,
  parameter logic [31:0] EXT_SIZE   = 32'h8,
  parameter logic [31:0] MAGIC_BE   = 32'hBEBE_BEBE,
  parameter logic [31:0] MAGIC_LE   = 32'h1E1E_1E1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [15:0]       out_enable,
  output logic [15:0]       out_bpp,
  output logic [15:0]       out_xres,
  output logic [15:0]       out_yres,
  output logic [15:0]       out_vwidth,
  output logic [15:0]       out_xoff,
  output logic [15:0]       out_yoff,
  output logic              out_big_endian
);

  localparam int          IDX_W   = ADDR_W;
  localparam logic [15:0] VMEM_64 = vmem_units(VMEM_BYTES);

  logic [1:0][IDX_W-1:0] lane_idx;
  logic [1:0]            lane_on;
  logic [1:0][1:0]       lane_be;
  logic [1:0][15:0]      lane_dat;
  logic [NREG-1:0][15:0] regs;
  logic [1:0][15:0]      slot_val;
  logic [31:0]           ext_rd;
  logic [31:0]           rd_next;
  logic                  bank_wr, rd_evt;

  assign bank_wr = req && wr && !win;
  assign rd_evt  = req && !wr;

  dcr_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .addr(addr), .size(size), .wdata(wdata),
    .lane_idx(lane_idx), .lane_on(lane_on), .lane_be(lane_be), .lane_dat(lane_dat)
  );

  dcr_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr),
    .lane_idx(lane_idx), .lane_on(lane_on), .lane_be(lane_be), .lane_dat(lane_dat),
    .regs(regs)
  );

  dcr_ext #(
    .ADDR_W(ADDR_W), .EXT_SIZE(EXT_SIZE), .MAGIC_BE(MAGIC_BE), .MAGIC_LE(MAGIC_LE)
  ) u_ext (
    .clk(clk), .rst_n(rst_n), .acc(req && win), .wr(wr), .addr(addr),
    .size(size), .wdata(wdata), .big_endian(out_big_endian), .rd_val(ext_rd)
  );

  // Per-lane slot read: synthesized slots first, then storage, then all ones
  for (genvar l = 0; l < 2; l++) begin : g_rd
    always_comb begin
      if (lane_idx[l] == IDX_W'(SLOT_ID))        slot_val[l] = VERSION_ID;
      else if (lane_idx[l] == IDX_W'(SLOT_VMEM)) slot_val[l] = VMEM_64;
      else if (lane_idx[l] < IDX_W'(NREG)) begin
        slot_val[l] = 16'h0;
        for (int i = 0; i < NREG; i++)
          if (lane_idx[l] == IDX_W'(i)) slot_val[l] = regs[i];
      end else                                   slot_val[l] = 16'hFFFF;
    end
  end

  assign rd_next = win ? ext_rd
                       : pack_read(acc_size_e'(size), addr[0], slot_val[0], slot_val[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= 32'h0;
    end else begin
      rvalid <= rd_evt;
      if (rd_evt) rdata <= rd_next;
    end
  end

  assign out_xres   = regs[SLOT_XRES];
  assign out_yres   = regs[SLOT_YRES];
  assign out_bpp    = regs[SLOT_BPP];
  assign out_enable = regs[SLOT_ENABLE];
  assign out_vwidth = regs[SLOT_VWIDTH];
  assign out_xoff   = regs[SLOT_XOFF];
  assign out_yoff   = regs[SLOT_YOFF];

  p_resp_follows_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rvalid);
  p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> !rvalid);
  p_version_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !win && size == 2'd1 && addr[ADDR_W-1:1] == '0)
      |=> rdata == {16'h0, VERSION_ID});

endmodule

// File: tb/dispctl_regs_test.sv
module dispctl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, win = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [15:0] out_enable, out_bpp, out_xres, out_yres, out_vwidth, out_xoff, out_yoff;
  logic        out_big_endian;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_regs uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .win(win), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .out_enable(out_enable), .out_bpp(out_bpp), .out_xres(out_xres),
    .out_yres(out_yres), .out_vwidth(out_vwidth), .out_xoff(out_xoff),
    .out_yoff(out_yoff), .out_big_endian(out_big_endian)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 unexpected response actual=%08h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic acc_wr(input logic w, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; win = w; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic acc_rd(input string tag, input logic w, input logic [7:0] a,
                        input logic [1:0] sz, input logic [31:0] exp);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; win = w; addr = a; size = sz;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 xres", {16'h0, out_xres}, 32'h0);
    chk("R10 enable", {16'h0, out_enable}, 32'h0);
    chk("R10 flag", {31'h0, out_big_endian}, 32'h0);
    chk("R10 rvalid", {31'h0, rvalid}, 32'h0);

    // R1 halfword stores
    acc_wr(0, 8'd2,  2'd1, 32'hDEAD_0400);
    chk("R1 xres port", {16'h0, out_xres}, 32'h0400);
    acc_rd("R1 xres readback", 0, 8'd2, 2'd1, 32'h0000_0400);
    acc_wr(0, 8'd5,  2'd1, 32'h0000_0300); // bit 0 ignored -> slot 2
    acc_wr(0, 8'd6,  2'd1, 32'h0000_0020);
    acc_wr(0, 8'd8,  2'd1, 32'h0000_0001);
    acc_wr(0, 8'd12, 2'd1, 32'h0000_0500);
    acc_wr(0, 8'd16, 2'd1, 32'h0000_0010);
    acc_wr(0, 8'd18, 2'd1, 32'h0000_0020);
    chk("R1 yres port", {16'h0, out_yres}, 32'h0300);
    chk("R1 bpp port", {16'h0, out_bpp}, 32'h0020);
    chk("R1 enable port", {16'h0, out_enable}, 32'h0001);
    chk("R1 vwidth port", {16'h0, out_vwidth}, 32'h0500);
    chk("R1 xoff port", {16'h0, out_xoff}, 32'h0010);
    chk("R1 yoff port", {16'h0, out_yoff}, 32'h0020);

    // R2 version constant
    acc_wr(0, 8'd0, 2'd1, 32'h0000_1234);
    acc_rd("R2 version", 0, 8'd0, 2'd1, 32'h0000_B0C5);

    // R3 memory size slot, R4 writes to it ignored
    acc_rd("R3 vmem", 0, 8'd20, 2'd1, 32'h0000_0100);
    acc_wr(0, 8'd20, 2'd1, 32'h0000_AAAA);
    acc_rd("R4 vmem after write", 0, 8'd20, 2'd1, 32'h0000_0100);

    // R4 out of range
    acc_rd("R4 oor half", 0, 8'd22, 2'd1, 32'h0000_FFFF);
    acc_rd("R4 oor word", 0, 8'd22, 2'd2, 32'hFFFF_FFFF);
    acc_rd("R4 oor byte", 0, 8'd23, 2'd0, 32'h0000_00FF);
    acc_wr(0, 8'd24, 2'd2, 32'h5555_5555);
    chk("R4 oor write xres", {16'h0, out_xres}, 32'h0400);
    chk("R4 oor write yoff", {16'h0, out_yoff}, 32'h0020);

    // R6 word spanning stored and synthesized slots
    acc_rd("R6 word straddle", 0, 8'd18, 2'd2, 32'h0100_0020);

    // R5 byte lanes
    acc_wr(0, 8'd3, 2'd0, 32'h0000_0007);
    chk("R5 upper byte write", {16'h0, out_xres}, 32'h0700);
    acc_wr(0, 8'd16, 2'd0, 32'h0000_00AB);
    chk("R5 lower byte write", {16'h0, out_xoff}, 32'h00AB);
    acc_rd("R5 byte read hi", 0, 8'd3, 2'd0, 32'h0000_0007);
    acc_rd("R5 byte read lo", 0, 8'd2, 2'd0, 32'h0000_0000);

    // R6 word write to two slots
    acc_wr(0, 8'd12, 2'd2, 32'h0040_0600);
    chk("R6 vwidth low half", {16'h0, out_vwidth}, 32'h0600);
    acc_rd("R6 vheight high half", 0, 8'd14, 2'd1, 32'h0000_0040);

    // R7 extension size
    acc_rd("R7 ext size", 1, 8'd0, 2'd2, 32'h0000_0008);

    // R8 byte order
    acc_rd("R8 order default", 1, 8'd4, 2'd2, 32'h1E1E_1E1E);
    acc_wr(1, 8'd4, 2'd2, 32'hBEBE_BEBE);
    chk("R8 set flag", {31'h0, out_big_endian}, 32'h1);
    acc_rd("R8 order big", 1, 8'd4, 2'd2, 32'hBEBE_BEBE);
    acc_wr(1, 8'd4, 2'd2, 32'h1234_5678);
    chk("R8 non-magic ignored", {31'h0, out_big_endian}, 32'h1);
    acc_wr(1, 8'd4, 2'd2, 32'h1E1E_1E1E);
    chk("R8 clear flag", {31'h0, out_big_endian}, 32'h0);

    // R9 narrow and misplaced extension accesses
    acc_wr(1, 8'd4, 2'd1, 32'hBEBE_BEBE);
    chk("R9 narrow write ignored", {31'h0, out_big_endian}, 32'h0);
    acc_rd("R9 narrow read zero", 1, 8'd4, 2'd1, 32'h0);
    acc_wr(1, 8'd8, 2'd2, 32'hBEBE_BEBE);
    chk("R9 undefined offset write", {31'h0, out_big_endian}, 32'h0);
    acc_rd("R9 undefined offset read", 1, 8'd8, 2'd2, 32'h0);

    // R11 no response after writes, back-to-back reads each answered
    acc_wr(0, 8'd6, 2'd1, 32'h0000_0010);
    @(negedge clk);
    chk("R11 no resp after write", {31'h0, rvalid}, 32'h0);
    acc_rd("R11 read a", 0, 8'd6, 2'd1, 32'h0000_0010);
    acc_rd("R11 read b", 0, 8'd8, 2'd1, 32'h0000_0001);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 responses missing actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule